// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home-side controller of an invalidation-based coherence scheme. It keeps a directory in which every memory block has one presence bit per processor and a single dirty bit. A processor holding a valid copy has its presence bit set. The dirty bit tells whether local memory holds the current data (0) or a single remote cache holds a modified copy (1). Next to the directory sits the block's backing data memory.

Requests arrive on a valid/ready request channel: read miss, write miss and write-back. Cache replies come in on a separate response channel: invalidation acknowledgments, and data returned by an owner. All outgoing traffic leaves on one valid/ready message channel: forwards to an owner, invalidations to sharers, and data replies to the requester. The controller serves one transaction at a time.

When an owner is involved, the owner returns its data only to the home. The home then updates memory where needed and relays the data to the requester. Invalidations go out one per cycle, starting from the lowest processor index. A counter tracks the acknowledgments still owed, and the data reply is held until that counter reaches zero.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is clean, with all presence bits 0 and dirty 0, and memory holds zero. `req_ready` is 1 and `out_valid` is 0.
- R2: A read miss (type 0) from processor i to a clean block returns one data message (type 7) to i carrying the memory contents, and sets presence[i].
- R3: A read miss to a dirty block sends a read forward (type 3) to the single owner j. When j's data arrives (response type 7), the home writes that data to memory, clears dirty, keeps presence[j] and sets presence[i], then sends the data to i.
- R4: A write miss (type 1) to a clean block sends an invalidation (type 5) to every other sharer, in ascending index order. The data reply is withheld until every acknowledgment (response type 6) has arrived. The block then ends with only presence[i] set and dirty 1.
- R5: The requester's own presence bit is never an invalidation target. If no other sharer exists, the data reply is sent at once with no invalidation.
- R6: A write miss to a dirty block sends a write forward (type 4) to the owner j. The owner's data is relayed to i. presence[j] is cleared, presence[i] is set, and dirty stays 1.
- R7: A write-back (type 2) from i writes its data into memory and clears dirty and presence[i]. No message is sent.
- R8: A presence bit left stale by a silent drop of a shared copy still receives an invalidation, and its acknowledgment is required before the data reply.
- R9: Once a read or write miss is accepted, `req_ready` stays 0 until that transaction's data reply has been accepted.
- R10: No acknowledgment is ever expected beyond the number of invalidations issued. Until the count reaches zero, no data message is sent.
- R11: While `out_valid` is 1 and `out_ready` is 0, the outgoing message (type, destination, block, data) holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and taking a request |
| req_type | input | 3 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_blk | input | $clog2(NBLK) | Block index |
| req_data | input | DW | Write-back data |
| rsp_valid | input | 1 | Cache response offered |
| rsp_ready | output | 1 | Controller waiting for responses |
| rsp_type | input | 3 | 6 acknowledgment, 7 owner data |
| rsp_src | input | $clog2(NPROC) | Responding processor |
| rsp_data | input | DW | Owner data |
| out_valid | output | 1 | Outgoing message offered |
| out_ready | input | 1 | Network takes the message |
| out_type | output | 3 | 3 read forward, 4 write forward, 5 invalidate, 7 data |
| out_dst | output | $clog2(NPROC) | Destination processor |
| out_blk | output | $clog2(NBLK) | Block index |
| out_data | output | DW | Data for type 7 |

## Verification
The bench builds the block with its defaults: four processors, sixteen blocks and 32-bit data. Four processors are enough for a write miss that must invalidate two sharers while skipping the requester. They also allow an owner hand-off, after which a third processor's read has to reach the new owner rather than the old one. Sixteen blocks let each scenario use a fresh block, so directory state left by one case cannot hide a fault in another. The message channel is held stalled for a cycle on every message, so hold behaviour is checked on every message type.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [2:0] {
      MSG_RDMISS = 3'd0,
      MSG_WRMISS = 3'd1,
      MSG_WBACK  = 3'd2,
      MSG_FWD_RD = 3'd3,
      MSG_FWD_WR = 3'd4,
      MSG_INV    = 3'd5,
      MSG_ACK    = 3'd6,
      MSG_DATA   = 3'd7
   } msg_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_FWD  = 3'd1,
      ST_OWN  = 3'd2,
      ST_INV  = 3'd3,
      ST_ACK  = 3'd4,
      ST_DATA = 3'd5
   } st_e;
endpackage

// File: rtl/dir_bit_scan.sv
module dir_bit_scan #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1,
   localparam int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] low_idx,
   output logic [CW-1:0] ones
);
   always_comb begin
      low_idx = '0;
      ones    = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (vec[k]) low_idx = IW'(k);
      end
      for (int k = 0; k < N; k++) begin
         ones = ones + CW'(vec[k]);
      end
   end
endmodule

// File: rtl/dir_entry_store.sv
module dir_entry_store #(
   parameter int NPROC = 4,
   parameter int NBLK  = 16,
   parameter int DW    = 32,
   localparam int BW = $clog2(NBLK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BW-1:0]    addr,
   output logic [NPROC-1:0] pres_o,
   output logic             dirty_o,
   output logic [DW-1:0]    data_o,
   input  logic             dir_we,
   input  logic [NPROC-1:0] pres_i,
   input  logic             dirty_i,
   input  logic             mem_we,
   input  logic [DW-1:0]    data_i
);
   logic [NPROC-1:0] pres_a  [NBLK];
   logic             dirty_a [NBLK];
   logic [DW-1:0]    data_a  [NBLK];

   for (genvar b = 0; b < NBLK; b++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pres_a[b]  <= '0;
            dirty_a[b] <= 1'b0;
            data_a[b]  <= '0;
         end else if (addr == BW'(b)) begin
            if (dir_we) begin
               pres_a[b]  <= pres_i;
               dirty_a[b] <= dirty_i;
            end
            if (mem_we) data_a[b] <= data_i;
         end
      end
   end

   assign pres_o  = pres_a[addr];
   assign dirty_o = dirty_a[addr];
   assign data_o  = data_a[addr];
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
   import dir_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int NBLK  = 16,
   parameter int DW    = 32,
   localparam int IW = $clog2(NPROC),
   localparam int BW = $clog2(NBLK),
   localparam int CW = $clog2(NPROC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [2:0]    req_type,
   input  logic [IW-1:0] req_src,
   input  logic [BW-1:0] req_blk,
   input  logic [DW-1:0] req_data,
   input  logic          rsp_valid,
   output logic          rsp_ready,
   input  logic [2:0]    rsp_type,
   input  logic [IW-1:0] rsp_src,
   input  logic [DW-1:0] rsp_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [2:0]    out_type,
   output logic [IW-1:0] out_dst,
   output logic [BW-1:0] out_blk,
   output logic [DW-1:0] out_data
);
   if (NPROC < 2) begin : g_bad_nproc
      $error("dir_home_ctrl: NPROC must be at least 2");
   end
   if (NBLK < 2) begin : g_bad_nblk
      $error("dir_home_ctrl: NBLK must be at least 2");
   end

   st_e              st_q, st_n;
   logic [IW-1:0]    src_q, src_n, own_q, own_n;
   logic [BW-1:0]    blk_q, blk_n;
   logic             wr_q, wr_n;
   logic [DW-1:0]    dat_q, dat_n;
   logic [NPROC-1:0] tgt_q, tgt_n;
   logic [CW-1:0]    ack_cnt_q, ack_cnt_n;

   logic [BW-1:0]    addr;
   logic [NPROC-1:0] rd_pres, pres_wr;
   logic             rd_dirty, dirty_wr, dir_we, mem_we;
   logic [DW-1:0]    rd_data, mem_wd;
   logic [IW-1:0]    own_idx, inv_idx;
   logic [CW-1:0]    sharer_cnt, left_cnt, other_cnt;
   logic [NPROC-1:0] req_oh, src_oh;
   logic             take_req, take_rsp, out_fire;

   assign addr = (st_q == ST_IDLE) ? req_blk : blk_q;

   dir_entry_store #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .pres_o(rd_pres), .dirty_o(rd_dirty), .data_o(rd_data),
      .dir_we(dir_we), .pres_i(pres_wr), .dirty_i(dirty_wr),
      .mem_we(mem_we), .data_i(mem_wd)
   );

   dir_bit_scan #(.N(NPROC)) u_scan_entry (
      .vec(rd_pres), .low_idx(own_idx), .ones(sharer_cnt)
   );

   dir_bit_scan #(.N(NPROC)) u_scan_left (
      .vec(tgt_q), .low_idx(inv_idx), .ones(left_cnt)
   );

   assign req_oh    = NPROC'(1) << req_src;
   assign src_oh    = NPROC'(1) << src_q;
   assign other_cnt = sharer_cnt - CW'(rd_pres[req_src]);

   assign req_ready = (st_q == ST_IDLE);
   assign rsp_ready = (st_q == ST_OWN) || (st_q == ST_INV) || (st_q == ST_ACK);
   assign out_valid = (st_q == ST_FWD) || (st_q == ST_INV) || (st_q == ST_DATA);
   assign take_req  = req_valid && req_ready;
   assign take_rsp  = rsp_valid && rsp_ready;
   assign out_fire  = out_valid && out_ready;

   always_comb begin
      case (st_q)
         ST_FWD:  out_type = wr_q ? MSG_FWD_WR : MSG_FWD_RD;
         ST_INV:  out_type = MSG_INV;
         default: out_type = MSG_DATA;
      endcase
      case (st_q)
         ST_FWD:  out_dst = own_q;
         ST_INV:  out_dst = inv_idx;
         default: out_dst = src_q;
      endcase
   end
   assign out_blk  = blk_q;
   assign out_data = dat_q;

   always_comb begin
      st_n = st_q; src_n = src_q; own_n = own_q; blk_n = blk_q;
      wr_n = wr_q; dat_n = dat_q; tgt_n = tgt_q; ack_cnt_n = ack_cnt_q;
      dir_we = 1'b0; pres_wr = rd_pres; dirty_wr = rd_dirty;
      mem_we = 1'b0; mem_wd = rd_data;
      case (st_q)
         ST_IDLE: if (take_req) begin
            src_n = req_src;
            blk_n = req_blk;
            wr_n  = (req_type == MSG_WRMISS);
            if (req_type == MSG_WBACK) begin
               mem_we = 1'b1; mem_wd = req_data;
               dir_we = 1'b1; pres_wr = rd_pres & ~req_oh; dirty_wr = 1'b0;
            end else if (req_type == MSG_RDMISS || req_type == MSG_WRMISS) begin
               if (rd_dirty) begin
                  own_n = own_idx;
                  st_n  = ST_FWD;
               end else if (req_type == MSG_RDMISS) begin
                  dir_we = 1'b1; pres_wr = rd_pres | req_oh; dirty_wr = 1'b0;
                  dat_n = rd_data;
                  st_n  = ST_DATA;
               end else if (other_cnt == '0) begin
                  dir_we = 1'b1; pres_wr = req_oh; dirty_wr = 1'b1;
                  dat_n = rd_data;
                  st_n  = ST_DATA;
               end else begin
                  tgt_n     = rd_pres & ~req_oh;
                  ack_cnt_n = other_cnt;
                  st_n      = ST_INV;
               end
            end
         end
         ST_FWD: if (out_fire) st_n = ST_OWN;
         ST_OWN: if (take_rsp && rsp_type == MSG_DATA && rsp_src == own_q) begin
            dat_n  = rsp_data;
            dir_we = 1'b1;
            if (wr_q) begin
               pres_wr = src_oh; dirty_wr = 1'b1;
            end else begin
               mem_we = 1'b1; mem_wd = rsp_data;
               pres_wr = rd_pres | src_oh; dirty_wr = 1'b0;
            end
            st_n = ST_DATA;
         end
         ST_INV: if (out_fire) begin
            tgt_n = tgt_q & ~(NPROC'(1) << inv_idx);
            if (tgt_n == '0) st_n = ST_ACK;
         end
         ST_ACK: if (ack_cnt_q == '0) begin
            dir_we = 1'b1; pres_wr = src_oh; dirty_wr = 1'b1;
            dat_n = rd_data;
            st_n  = ST_DATA;
         end
         ST_DATA: if (out_fire) st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
      if (take_rsp && rsp_type == MSG_ACK && (st_q == ST_INV || st_q == ST_ACK)
          && ack_cnt_q != '0)
         ack_cnt_n = ack_cnt_q - CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; src_q <= '0; own_q <= '0; blk_q <= '0;
         wr_q <= 1'b0; dat_q <= '0; tgt_q <= '0; ack_cnt_q <= '0;
      end else begin
         st_q <= st_n; src_q <= src_n; own_q <= own_n; blk_q <= blk_n;
         wr_q <= wr_n; dat_q <= dat_n; tgt_q <= tgt_n; ack_cnt_q <= ack_cnt_n;
      end
   end

   AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (take_req && (req_type == MSG_RDMISS || req_type == MSG_WRMISS)) |=> !req_ready); // R9
   AST_ACK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (take_rsp && rsp_type == MSG_ACK && (st_q == ST_INV || st_q == ST_ACK)) |-> ack_cnt_q != '0); // R10
   AST_ACK_COVERS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_INV) |-> ack_cnt_q >= left_cnt); // R10
   AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid && $stable(out_type) && $stable(out_dst)
                                    && $stable(out_blk) && $stable(out_data)); // R11
   AST_INV_SKIPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_type == MSG_INV) |-> out_dst != src_q); // R5
   AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      rd_dirty |-> sharer_cnt == CW'(1)); // R6
endmodule

// File: tb/sim_dir_home_ctrl.sv
`timescale 1ns/1ps
module sim_dir_home_ctrl;
   localparam int NPROC = 4, NBLK = 16, DW = 32;
   localparam int IW = $clog2(NPROC), BW = $clog2(NBLK);
   localparam logic [2:0] T_RD = 3'd0, T_WR = 3'd1, T_WB = 3'd2, T_FRD = 3'd3,
                          T_FWR = 3'd4, T_INV = 3'd5, T_ACK = 3'd6, T_DAT = 3'd7;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [2:0] req_type = '0;
   logic [IW-1:0] req_src = '0;
   logic [BW-1:0] req_blk = '0;
   logic [DW-1:0] req_data = '0;
   logic rsp_valid = 1'b0, rsp_ready;
   logic [2:0] rsp_type = '0;
   logic [IW-1:0] rsp_src = '0;
   logic [DW-1:0] rsp_data = '0;
   logic out_valid, out_ready = 1'b0;
   logic [2:0] out_type;
   logic [IW-1:0] out_dst;
   logic [BW-1:0] out_blk;
   logic [DW-1:0] out_data;

   int checks = 0, failures = 0, cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dir_home_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
      .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type),
      .rsp_src(rsp_src), .rsp_data(rsp_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
      .out_dst(out_dst), .out_blk(out_blk), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_req(input logic [2:0] t, input int src, input int blk, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_type = t; req_src = IW'(src); req_blk = BW'(blk); req_data = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic send_rsp(input logic [2:0] t, input int src, input logic [DW-1:0] d);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_type = t; rsp_src = IW'(src); rsp_data = d;
      while (!rsp_ready) @(negedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   // waits for a message, checks it, holds it stalled one cycle (R11), then takes it
   task automatic expect_msg(input logic [2:0] t, input int dst, input int blk,
                             input logic [DW-1:0] d, input string tag);
      int n = 0;
      while (!out_valid && n < 40) begin
         @(negedge clk); n++;
      end
      chk(out_valid, {tag, " msg present"}, out_valid, 1);
      chk(out_type == t, {tag, " type"}, out_type, t);
      chk(out_dst == IW'(dst), {tag, " dst"}, out_dst, dst);
      chk(out_blk == BW'(blk), {tag, " blk"}, out_blk, blk);
      if (t == T_DAT) chk(out_data == d, {tag, " data"}, out_data, d);
      @(negedge clk);
      chk(out_valid && out_type == t && out_dst == IW'(dst), "R11 held while stalled",
          {out_valid, out_type, 2'(out_dst)}, {1'b1, t, 2'(dst)});
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic quiet(input int ncyc, input string tag);
      for (int k = 0; k < ncyc; k++) begin
         @(negedge clk);
         chk(!out_valid, tag, out_valid, 0);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      chk(out_valid == 1'b0, "R1 no message after reset", out_valid, 0);
      send_req(T_RD, 0, 0, '0);
      expect_msg(T_DAT, 0, 0, 32'h0, "R1 R2 clean read of reset memory");
   endtask

   task automatic t_inv_write;
      send_req(T_WB, 3, 3, 32'h33);
      quiet(2, "R7 write-back sends nothing");
      send_req(T_RD, 1, 3, '0);
      expect_msg(T_DAT, 1, 3, 32'h33, "R2 R7 read returns written-back data");
      send_req(T_RD, 2, 3, '0);
      expect_msg(T_DAT, 2, 3, 32'h33, "R2 second sharer");
      send_req(T_WR, 0, 3, '0);
      expect_msg(T_INV, 1, 3, '0, "R4 first invalidation");
      expect_msg(T_INV, 2, 3, '0, "R4 second invalidation");
      @(negedge clk);
      chk(req_ready == 1'b0, "R9 busy during transaction", req_ready, 0);
      quiet(3, "R10 no data before acks");
      send_rsp(T_ACK, 1, '0);
      quiet(3, "R10 no data after one of two acks");
      send_rsp(T_ACK, 2, '0);
      expect_msg(T_DAT, 0, 3, 32'h33, "R4 data after all acks");
      @(negedge clk);
      chk(req_ready == 1'b1, "R9 ready after completion", req_ready, 1);
   endtask

   task automatic t_excl;
      send_req(T_RD, 1, 5, '0);
      expect_msg(T_DAT, 1, 5, 32'h0, "R2 read blk5");
      send_req(T_WR, 1, 5, '0);
      expect_msg(T_DAT, 1, 5, 32'h0, "R5 own bit excluded, immediate data");
   endtask

   task automatic t_dirty_read;
      send_req(T_RD, 2, 3, '0);
      expect_msg(T_FRD, 0, 3, '0, "R3 read forward to owner");
      send_rsp(T_DAT, 0, 32'hABCD);
      expect_msg(T_DAT, 2, 3, 32'hABCD, "R3 owner data relayed");
      send_req(T_WR, 3, 3, '0);
      expect_msg(T_INV, 0, 3, '0, "R3 old owner kept as sharer");
      expect_msg(T_INV, 2, 3, '0, "R3 reader became sharer");
      send_rsp(T_ACK, 0, '0);
      send_rsp(T_ACK, 2, '0);
      expect_msg(T_DAT, 3, 3, 32'hABCD, "R3 memory updated from owner");
   endtask

   task automatic t_dirty_write;
      send_req(T_WR, 1, 3, '0);
      expect_msg(T_FWR, 3, 3, '0, "R6 write forward to owner");
      send_rsp(T_DAT, 3, 32'h1234);
      expect_msg(T_DAT, 1, 3, 32'h1234, "R6 owner data relayed");
      send_req(T_RD, 2, 3, '0);
      expect_msg(T_FRD, 1, 3, '0, "R6 ownership moved to requester");
      send_rsp(T_DAT, 1, 32'h5555);
      expect_msg(T_DAT, 2, 3, 32'h5555, "R6 new owner data relayed");
   endtask

   task automatic t_writeback;
      send_req(T_WR, 0, 7, '0);
      expect_msg(T_DAT, 0, 7, 32'h0, "R5 write with no sharers");
      send_req(T_WB, 0, 7, 32'h77);
      quiet(2, "R7 write-back silent");
      send_req(T_RD, 1, 7, '0);
      expect_msg(T_DAT, 1, 7, 32'h77, "R7 clean after write-back");
      send_req(T_WR, 2, 7, '0);
      expect_msg(T_INV, 1, 7, '0, "R7 writer presence cleared");
      send_rsp(T_ACK, 1, '0);
      expect_msg(T_DAT, 2, 7, 32'h77, "R7 data after ack");
   endtask

   task automatic t_stale;
      send_req(T_RD, 1, 9, '0);
      expect_msg(T_DAT, 1, 9, 32'h0, "R8 sharer one");
      send_req(T_RD, 2, 9, '0);
      expect_msg(T_DAT, 2, 9, 32'h0, "R8 sharer two");
      send_req(T_WR, 3, 9, '0);
      expect_msg(T_INV, 1, 9, '0, "R8 stale sharer invalidated");
      expect_msg(T_INV, 2, 9, '0, "R8 live sharer invalidated");
      send_rsp(T_ACK, 2, '0);
      quiet(3, "R8 stale ack still awaited");
      send_rsp(T_ACK, 1, '0);
      expect_msg(T_DAT, 3, 9, 32'h0, "R8 data after stale ack");
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc == 20000 && !done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_inv_write();
      t_excl();
      t_dirty_read();
      t_dirty_write();
      t_writeback();
      t_stale();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule